// File: doc/BRIEF.md
# Attraction Memory Slot Controller

This block treats a node's local memory as a direct-mapped cache of global lines. Each slot records which global line it holds (a tag) and what role its copy plays: empty, an extra replica, the single owning copy in clean form, the owning copy in modified form, or an owning copy that has been handed away and is waiting for a receipt. Every processor miss is first checked against the slot it maps to. If the tag and state can serve the access, the miss is answered locally. If not, a remote fetch goes out, one cycle later than an untagged path would have sent it.

Replies from the network come in as fills. A fill is always passed on to the processor first. Only after that does the controller inspect the slot it is about to overwrite. Overwriting a replica or an empty slot costs nothing. Overwriting an owning copy produces a displacement message so the last copy of that line survives. That message must be accepted by the output before the slot changes. When the displaced owner was modified, the slot holds a pending marker, and the controller stalls until a receipt for that slot index arrives.

One serial state machine sequences all of this through the states Idle, Lookup, Forward, Victim, Displace, WaitAck and Commit. The transitions are:
- Idle to Forward when a fill is accepted.
- Idle to Lookup when a request is accepted.
- Lookup back to Idle.
- Forward to Victim.
- Victim to Displace or Commit.
- Displace to WaitAck or Commit once the output accepts.
- WaitAck to Commit on a matching receipt.
- Commit back to Idle.

Top module: `attr_mem_ctrl`

## Requirements
- R1: After reset every slot is empty, so the first lookup of any line reports a miss. At reset `req_ready` and `fill_ready` are high and no output valid is asserted.
- R2: A lookup result (`res_valid`, `res_hit`, `res_addr`) appears exactly one cycle after the request is accepted. On a miss, `fetch_valid` is asserted in that same cycle with the request's line address and write flag.
- R3: A line address maps to slot index = its low IDX_W bits, and its tag is the remaining upper bits. A read hits when the slot tag matches and the slot holds a replica or an owning copy.
- R4: A write hits only when the slot holds the owning copy (clean or modified). A write to a replica is a miss. A write hit on a clean owning copy turns the slot into a modified owning copy.
- R5: A fill produces `fwd_valid` with the fill address exactly one cycle after acceptance. This happens before any displacement message for that fill, and only one of result, forward and displacement is active in any cycle.
- R6: A fill installs a modified owner when both `fill_master` and `fill_dirty` are set, a clean owner when only `fill_master` is set, and a replica otherwise.
- R7: Installing over an empty slot, over a replica, or over the same line sends no displacement message.
- R8: Installing a different line over an owning copy sends one displacement message. Its `disp_addr` is the victim's full line address, and `disp_dirty` is 1 only if the victim was modified.
- R9: While `disp_valid` waits for `disp_ready`, the message stays stable, the slot keeps its old line, and no new request or fill is accepted.
- R10: After a modified owner is displaced, both ready outputs stay low until `ack_valid` arrives with `ack_idx` equal to that slot index. Receipts for other indices are ignored. The new line is installed two cycles after the matching receipt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor miss request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Line address of the miss |
| req_write | input | 1 | Miss is for a write |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup served locally |
| res_addr | output | ADDR_W | Line address of the result |
| fetch_valid | output | 1 | Remote fetch request |
| fetch_addr | output | ADDR_W | Line to fetch |
| fetch_write | output | 1 | Fetch is for a write |
| fill_valid | input | 1 | Reply fill present |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_addr | input | ADDR_W | Line address of the fill |
| fill_master | input | 1 | Fill carries ownership |
| fill_dirty | input | 1 | Owned fill is modified |
| fwd_valid | output | 1 | Fill forwarded to processor |
| fwd_addr | output | ADDR_W | Forwarded line address |
| disp_valid | output | 1 | Displacement message pending |
| disp_ready | input | 1 | Output resource free |
| disp_addr | output | ADDR_W | Displaced line address |
| disp_dirty | output | 1 | Displaced owner was modified |
| ack_valid | input | 1 | Displacement receipt |
| ack_idx | input | IDX_W | Slot index the receipt is for |

## Verification
The bench builds the controller with ADDR_W = 8 and IDX_W = 2, which gives four slots and six-bit tags. With only four slots, a handful of addresses that differ only in the upper bits collide on one slot. This makes it easy to cover every victim class: empty, replica, same line, clean owner and modified owner. The same small configuration also covers a withheld output resource, a stalled receipt and a wrong-index receipt. A bench-side slot model predicts hits, fetches and displacements, and checks the one-cycle spacing of results and forwards.

// File: rtl/am_pkg.sv
package am_pkg;

    typedef enum logic [2:0] {
        SL_EMPTY   = 3'd0,
        SL_REPLICA = 3'd1,
        SL_OWN_CLN = 3'd2,
        SL_OWN_MOD = 3'd3,
        SL_PENDING = 3'd4
    } slot_st_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_LOOKUP,
        C_FORWARD,
        C_VICTIM,
        C_DISPLACE,
        C_WAITACK,
        C_COMMIT
    } ctrl_st_e;

    function automatic logic is_owner(input slot_st_e st);
        return (st == SL_OWN_CLN) || (st == SL_OWN_MOD);
    endfunction

    function automatic slot_st_e install_state(input logic master, input logic dirty);
        if (master && dirty) return SL_OWN_MOD;
        if (master)          return SL_OWN_CLN;
        return SL_REPLICA;
    endfunction

endpackage

// File: rtl/am_slot_array.sv
module am_slot_array
    import am_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output slot_st_e         rd_st,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  slot_st_e         wr_st
);
    localparam int NSLOT = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [NSLOT];
    slot_st_e         st_q  [NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                tag_q[s] <= '0;
                st_q[s]  <= SL_EMPTY;
            end
        end else if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            st_q[wr_idx]  <= wr_st;
        end
    end

    assign rd_tag = tag_q[rd_idx];
    assign rd_st  = st_q[rd_idx];

endmodule

// File: rtl/am_tag_check.sv
module am_tag_check
    import am_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic [TAG_W-1:0] slot_tag,
    input  slot_st_e         slot_st,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             look_write,
    output logic             hit,
    output logic             upgrade
);
    logic same_line;
    logic can_read;

    always_comb begin
        same_line = (slot_tag == look_tag);
        can_read  = (slot_st == SL_REPLICA) || is_owner(slot_st);
        if (look_write) begin
            hit = same_line && is_owner(slot_st);
        end else begin
            hit = same_line && can_read;
        end
        upgrade = look_write && same_line && (slot_st == SL_OWN_CLN);
    end

endmodule

// File: rtl/am_victim_sel.sv
module am_victim_sel
    import am_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic [TAG_W-1:0] slot_tag,
    input  slot_st_e         slot_st,
    input  logic [TAG_W-1:0] new_tag,
    output logic             need_msg,
    output logic             msg_dirty
);
    always_comb begin
        need_msg  = is_owner(slot_st) && (slot_tag != new_tag);
        msg_dirty = need_msg && (slot_st == SL_OWN_MOD);
    end

endmodule

// File: rtl/attr_mem_ctrl.sv
module attr_mem_ctrl
    import am_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              res_valid,
    output logic              res_hit,
    output logic [ADDR_W-1:0] res_addr,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_write,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_master,
    input  logic              fill_dirty,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [ADDR_W-1:0] disp_addr,
    output logic              disp_dirty,
    input  logic              ack_valid,
    input  logic [IDX_W-1:0]  ack_idx
);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctrl_st_e          state, nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic              cur_master;
    logic              cur_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic              vic_dirty;

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [TAG_W-1:0]  slot_tag;
    slot_st_e          slot_st;
    logic              lk_hit;
    logic              lk_upgrade;
    logic              need_msg;
    logic              msg_dirty;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    slot_st_e          wr_st;

    assign cur_idx = cur_addr[IDX_W-1:0];
    assign cur_tag = cur_addr[ADDR_W-1:IDX_W];

    am_slot_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (cur_idx),
        .rd_tag (slot_tag),
        .rd_st  (slot_st),
        .wr_en  (wr_en),
        .wr_idx (cur_idx),
        .wr_tag (wr_tag),
        .wr_st  (wr_st)
    );

    am_tag_check #(.TAG_W(TAG_W)) u_tagchk (
        .slot_tag   (slot_tag),
        .slot_st    (slot_st),
        .look_tag   (cur_tag),
        .look_write (cur_write),
        .hit        (lk_hit),
        .upgrade    (lk_upgrade)
    );

    am_victim_sel #(.TAG_W(TAG_W)) u_victim (
        .slot_tag  (slot_tag),
        .slot_st   (slot_st),
        .new_tag   (cur_tag),
        .need_msg  (need_msg),
        .msg_dirty (msg_dirty)
    );

    // state register and transaction latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= C_IDLE;
            cur_addr   <= '0;
            cur_write  <= 1'b0;
            cur_master <= 1'b0;
            cur_dirty  <= 1'b0;
            vic_tag    <= '0;
            vic_dirty  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == C_IDLE && fill_valid) begin
                cur_addr   <= fill_addr;
                cur_write  <= 1'b0;
                cur_master <= fill_master;
                cur_dirty  <= fill_dirty;
            end else if (state == C_IDLE && req_valid) begin
                cur_addr  <= req_addr;
                cur_write <= req_write;
            end
            if (state == C_VICTIM) begin
                vic_tag   <= slot_tag;
                vic_dirty <= msg_dirty;
            end
        end
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            C_IDLE: begin
                if (fill_valid)     nxt = C_FORWARD;
                else if (req_valid) nxt = C_LOOKUP;
            end
            C_LOOKUP:  nxt = C_IDLE;
            C_FORWARD: nxt = C_VICTIM;
            C_VICTIM:  nxt = need_msg ? C_DISPLACE : C_COMMIT;
            C_DISPLACE: begin
                if (disp_ready) nxt = vic_dirty ? C_WAITACK : C_COMMIT;
            end
            C_WAITACK: begin
                if (ack_valid && ack_idx == cur_idx) nxt = C_COMMIT;
            end
            C_COMMIT:  nxt = C_IDLE;
            default:   nxt = C_IDLE;
        endcase
    end

    // outputs and slot writes
    always_comb begin
        req_ready   = 1'b0;
        fill_ready  = 1'b0;
        res_valid   = 1'b0;
        res_hit     = 1'b0;
        fetch_valid = 1'b0;
        fwd_valid   = 1'b0;
        disp_valid  = 1'b0;
        wr_en       = 1'b0;
        wr_tag      = cur_tag;
        wr_st       = SL_EMPTY;
        unique case (state)
            C_IDLE: begin
                fill_ready = 1'b1;
                req_ready  = !fill_valid;
            end
            C_LOOKUP: begin
                res_valid   = 1'b1;
                res_hit     = lk_hit;
                fetch_valid = !lk_hit;
                if (lk_upgrade) begin
                    wr_en = 1'b1;
                    wr_st = SL_OWN_MOD;
                end
            end
            C_FORWARD: fwd_valid = 1'b1;
            C_VICTIM: ;
            C_DISPLACE: begin
                disp_valid = 1'b1;
                if (disp_ready && vic_dirty) begin
                    wr_en  = 1'b1;
                    wr_tag = vic_tag;
                    wr_st  = SL_PENDING;
                end
            end
            C_WAITACK: ;
            C_COMMIT: begin
                wr_en = 1'b1;
                wr_st = install_state(cur_master, cur_dirty);
            end
            default: ;
        endcase
    end

    assign res_addr    = cur_addr;
    assign fetch_addr  = cur_addr;
    assign fetch_write = cur_write;
    assign fwd_addr    = cur_addr;
    assign disp_addr   = {vic_tag, cur_idx};
    assign disp_dirty  = vic_dirty;

endmodule

// File: rtl/attr_mem_ctrl_checker.sv
module attr_mem_ctrl_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              res_valid,
    input logic              res_hit,
    input logic [ADDR_W-1:0] res_addr,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fill_valid,
    input logic              fill_ready,
    input logic              fwd_valid,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [ADDR_W-1:0] disp_addr,
    input logic              disp_dirty
);
    AST_REQ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> res_valid); // R2

    AST_FETCH_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> res_valid && !res_hit && fetch_addr == res_addr); // R2

    AST_FILL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && fill_ready |=> fwd_valid); // R5

    AST_FWD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !disp_valid); // R5

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, fwd_valid, disp_valid})); // R5

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_addr) && $stable(disp_dirty)); // R9

    AST_DIRTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready && disp_dirty |=> !fill_ready && !req_ready); // R10

endmodule

bind attr_mem_ctrl attr_mem_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_addr    (res_addr),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fill_valid  (fill_valid),
    .fill_ready  (fill_ready),
    .fwd_valid   (fwd_valid),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .disp_addr   (disp_addr),
    .disp_dirty  (disp_dirty)
);

// File: tb/attr_mem_ctrl_bench.sv
module attr_mem_ctrl_bench;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 2;
    localparam int NS     = 1 << IDX_W;
    localparam int M_EMPTY = 0, M_REP = 1, M_CLN = 2, M_MOD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic fill_valid = 1'b0, fill_master = 1'b0, fill_dirty = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic disp_ready = 1'b1;
    logic ack_valid = 1'b0;
    logic [IDX_W-1:0] ack_idx = '0;
    logic req_ready, res_valid, res_hit, fetch_valid, fetch_write;
    logic fill_ready, fwd_valid, disp_valid, disp_dirty;
    logic [ADDR_W-1:0] res_addr, fetch_addr, fwd_addr, disp_addr;

    attr_mem_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_attr_mem_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_write(fetch_write),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .fill_master(fill_master), .fill_dirty(fill_dirty),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_addr(disp_addr), .disp_dirty(disp_dirty),
        .ack_valid(ack_valid), .ack_idx(ack_idx)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int kind;   // 0 result, 1 forward, 2 displacement
        int addr;
        int hit;
        int wr;
        int dirty;
        int cyc;    // -1: any cycle
    } exp_t;

    exp_t sbq[$];
    int   mtag [NS];
    int   mst  [NS];
    int   cyc = 0;
    int   nchk = 0;
    int   nerr = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    task automatic take(input int kind, output exp_t it, output bit ok);
        if (sbq.size() == 0) begin
            check(1'b0, "R5 unexpected output", kind, -1);
            ok = 1'b0;
        end else begin
            it = sbq.pop_front();
            ok = 1'b1;
            check(it.kind == kind, "R5 output order", kind, it.kind);
        end
    endtask

    // monitor: pops expected items as outputs appear
    always @(negedge clk) begin
        exp_t it;
        bit ok;
        if (rst_n && !done) begin
            if (res_valid) begin
                take(0, it, ok);
                if (ok) begin
                    check(int'(res_addr) == it.addr, "R2 result address", res_addr, it.addr);
                    check(int'(res_hit) == it.hit, "R3 hit decision", res_hit, it.hit);
                    check(cyc == it.cyc, "R2 result cycle", cyc, it.cyc);
                    check(int'(fetch_valid) == 1 - it.hit, "R2 fetch on miss", fetch_valid, 1 - it.hit);
                    if (!it.hit) begin
                        check(int'(fetch_addr) == it.addr, "R2 fetch address", fetch_addr, it.addr);
                        check(int'(fetch_write) == it.wr, "R4 fetch write flag", fetch_write, it.wr);
                    end
                end
            end
            if (fwd_valid) begin
                take(1, it, ok);
                if (ok) begin
                    check(int'(fwd_addr) == it.addr, "R5 forward address", fwd_addr, it.addr);
                    check(cyc == it.cyc, "R5 forward cycle", cyc, it.cyc);
                end
            end
            if (disp_valid && disp_ready) begin
                take(2, it, ok);
                if (ok) begin
                    check(int'(disp_addr) == it.addr, "R8 victim address", disp_addr, it.addr);
                    check(int'(disp_dirty) == it.dirty, "R8 victim dirty", disp_dirty, it.dirty);
                end
            end
        end
    end

    task automatic do_req(input int addr, input int wr);
        int idx = addr % NS;
        int tg  = addr / NS;
        int hit;
        exp_t it;
        if (wr) hit = (mtag[idx] == tg) && (mst[idx] == M_CLN || mst[idx] == M_MOD);
        else    hit = (mtag[idx] == tg) && (mst[idx] != M_EMPTY);
        @(posedge clk); #1;
        req_addr = ADDR_W'(addr); req_write = wr[0]; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(posedge clk); #2; end
        it = '{kind: 0, addr: addr, hit: hit, wr: wr, dirty: 0, cyc: cyc + 1};
        sbq.push_back(it);
        if (wr && hit) mst[idx] = M_MOD;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic do_fill(input int addr, input int master, input int dirty, input bit hold);
        int idx = addr % NS;
        int tg  = addr / NS;
        int need, vdirty, vaddr;
        exp_t it;
        need   = (mst[idx] == M_CLN || mst[idx] == M_MOD) && (mtag[idx] != tg);
        vdirty = need && (mst[idx] == M_MOD);
        vaddr  = mtag[idx] * NS + idx;
        @(posedge clk); #1;
        if (hold) disp_ready = 1'b0;
        fill_addr = ADDR_W'(addr); fill_master = master[0]; fill_dirty = dirty[0]; fill_valid = 1'b1;
        #1;
        while (!fill_ready) begin @(posedge clk); #2; end
        it = '{kind: 1, addr: addr, hit: 0, wr: 0, dirty: 0, cyc: cyc + 1};
        sbq.push_back(it);
        if (need) begin
            it = '{kind: 2, addr: vaddr, hit: 0, wr: 0, dirty: vdirty, cyc: -1};
            sbq.push_back(it);
        end
        mtag[idx] = tg;
        mst[idx]  = master ? (dirty ? M_MOD : M_CLN) : M_REP;
        @(posedge clk); #1;
        fill_valid = 1'b0;
        if (hold) begin
            repeat (4) @(posedge clk);
            @(negedge clk);
            check(disp_valid == 1'b1, "R9 message held", disp_valid, 1);
            check(fill_ready == 1'b0 && req_ready == 1'b0, "R9 no accept while blocked", fill_ready, 0);
            check(int'(disp_addr) == vaddr, "R9 held address", disp_addr, vaddr);
            @(posedge clk); #1;
            disp_ready = 1'b1;
        end
        if (need && vdirty) begin
            @(negedge clk);
            while (!(disp_valid && disp_ready)) @(negedge clk);
            repeat (3) begin
                @(negedge clk);
                check(fill_ready == 1'b0 && req_ready == 1'b0, "R10 stall awaiting receipt", fill_ready, 0);
            end
            @(posedge clk); #1;
            ack_idx = IDX_W'(idx ^ 1); ack_valid = 1'b1;
            @(posedge clk); #1;
            ack_valid = 1'b0;
            @(negedge clk);
            check(fill_ready == 1'b0, "R10 other index receipt ignored", fill_ready, 0);
            @(posedge clk); #1;
            ack_idx = IDX_W'(idx); ack_valid = 1'b1;
            @(posedge clk); #1;
            ack_valid = 1'b0;
            @(negedge clk);
            check(fill_ready == 1'b0, "R10 commit cycle", fill_ready, 0);
            @(negedge clk);
            check(fill_ready == 1'b1, "R10 released after receipt", fill_ready, 1);
        end
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin mtag[i] = 0; mst[i] = M_EMPTY; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_valid == 0 && fwd_valid == 0 && disp_valid == 0 && fetch_valid == 0,
              "R1 outputs idle in reset", res_valid, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && fill_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        do_req(8'h05, 0);               // R1 empty slot: miss
        do_req(8'h05, 1);               // R2 write miss fetch flag
        do_fill(8'h05, 0, 0, 1'b0);     // R6 replica install, R7 empty victim
        do_req(8'h05, 0);               // R3 read hit replica
        do_req(8'h05, 1);               // R4 write on replica misses
        do_fill(8'h09, 1, 0, 1'b0);     // R7 replica victim, no message
        do_req(8'h09, 0);               // R3
        do_req(8'h05, 0);               // R3 displaced line misses
        do_req(8'h09, 1);               // R4 write hit, clean becomes modified
        do_fill(8'h0D, 0, 0, 1'b0);     // R8 R10 modified victim with receipt
        do_req(8'h0D, 0);               // R10 new line installed
        do_req(8'h09, 0);
        do_fill(8'h02, 1, 0, 1'b0);
        do_req(8'h02, 1);               // R4 write hit clean owner
        do_fill(8'h0E, 1, 0, 1'b1);     // R9 modified victim held, then R10
        do_fill(8'h03, 1, 0, 1'b0);
        do_fill(8'h07, 1, 1, 1'b1);     // R9 clean victim held
        do_req(8'h07, 1);               // R6 modified owner install: write hit
        do_req(8'h03, 0);               // R9 old line gone after commit
        do_fill(8'h07, 0, 0, 1'b0);     // R7 same line, no message
        do_req(8'h07, 1);               // R6 replica now: write misses
        do_fill(8'h01, 1, 1, 1'b0);     // R6 modified owner install
        do_fill(8'h11, 0, 0, 1'b0);     // R8 dirty flag reveals modified install
        do_req(8'h11, 0);

        repeat (6) @(posedge clk);
        @(negedge clk);
        check(sbq.size() == 0, "R8 all expected outputs seen", sbq.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL R2 watchdog: actual %0d expected below %0d", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule